// File: doc/BRIEF.md
# Microtagged Way-Predicting Cache Tag Path

This block holds the tags of a small 4-way set-associative data cache that is indexed with virtual address bits and tagged with physical addresses. Each line stores a valid bit, a short microtag taken from the virtual page bits just above the set index, and the full physical tag. In the cycle a request is accepted, the microtag of the request is compared against the four lines of its set. The matching way, one-hot, goes straight to the data array's output multiplexer, so data can leave the cache without waiting for the translation and the wide tag compare.

One cycle later the physical tag from the translation arrives. It is compared against the selected way to confirm the hit or cancel it. On a real miss the same physical tag is compared against every way of the set. The set index lies inside the page offset, so two virtual aliases of one physical line always land in the same set. A match therefore means the line is already present. It is then retagged to the new microtag and reported without any refill. Otherwise a refill is requested for a victim way. The victim is chosen so that microtags stay unique within a set.

The request port is valid/ready. A request is taken when `req_valid_i` and `req_ready_o` are both high. The block holds `req_ready_o` low in the check cycle and for as long as a refill is outstanding. The requester must keep its request steady until it is taken. The refill port is also valid/ready: `fill_ready_o` is high only while a refill is outstanding, and the refill engine may assert `fill_valid_i` whenever it is done. Responses are a single-cycle `resp_valid_o` pulse with no back-pressure. The consumer must take them in the cycle they appear. The set index plus line offset must not be wider than the page offset.

Top module: `mtc_lookup`

## Requirements
- R1: While `req_valid_i` is high, `early_way_o` is the one-hot code of the way whose line in set `vaddr[OFFSET_W +: IDX_W]` is valid and holds the microtag `vaddr[OFFSET_W+IDX_W +: UTAG_W]`. It is all zero when no such line exists.
- R2: In the cycle after acceptance, if the early way's physical tag equals `ptag_i`, the block gives `resp_valid_o`=1, `resp_kind_o`=0 (hit) and `resp_way_o` = that way.
- R3: When the microtag matches but the physical tag does not, no hit is reported. The access is handled as a miss.
- R4: On a miss where some valid way of the set holds `ptag_i`, the block gives `resp_kind_o`=1 (alias) with that way and issues no refill. That line takes the new microtag, and any other line of the set that held the new microtag is invalidated.
- R5: On a miss with no alias, `miss_valid_o` is high from the next cycle until the fill handshake, with the victim on `miss_way_o`. `req_ready_o` stays low during that time.
- R6: Victim choice: the way whose microtag matched, if any; otherwise the lowest-numbered invalid way; otherwise the way named by the pseudo-LRU bits.
- R7: In the cycle of the fill handshake, the victim line becomes valid with the pending microtag and physical tag. The block gives `resp_kind_o`=2 (filled) and `resp_way_o` = victim.
- R8: No two valid lines of one set share a microtag, so `early_way_o` never has more than one bit set.
- R9: After reset all lines are invalid, `req_ready_o` is 1, and `resp_valid_o`, `miss_valid_o` and `fill_ready_o` are 0.
- R10: Each set has 3 pseudo-LRU bits. Bit 0 = 0 selects ways 0–1, and bit 0 = 1 selects ways 2–3. Bit 1 picks way 1 over way 0 when it is 1. Bit 2 picks way 3 over way 2 when it is 1. Every response for way w sets bit 0 to (w<2) and flips the pair bit to point away from w.
- R11: Only one request is in flight. `req_ready_o` is 0 in the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_vaddr_i | input | VA_W | Virtual address of the request |
| early_way_o | output | 4 | One-hot way selected by microtag |
| ptag_i | input | PTAG_W | Physical tag, valid in the cycle after acceptance |
| resp_valid_o | output | 1 | Response pulse |
| resp_kind_o | output | 2 | 0 hit, 1 alias, 2 filled |
| resp_way_o | output | 2 | Way holding the line |
| miss_valid_o | output | 1 | Refill wanted |
| miss_way_o | output | 2 | Way to be refilled |
| fill_valid_i | input | 1 | Refill done |
| fill_ready_o | output | 1 | Refill awaited |

## Verification
The bench builds the block with 4 sets, a 3-bit microtag, a 4-bit physical tag and a 16-bit address. With these sizes, random traffic keeps refilling full sets. Microtag collisions with a different physical tag are frequent, and physical tags repeat under other microtags often enough to produce aliases. The 3-bit microtag gives 8 values for 4 ways, so misses with no microtag match in a full set still happen and exercise the pseudo-LRU choice.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {
    RK_HIT   = 2'd0,
    RK_ALIAS = 2'd1,
    RK_FILL  = 2'd2
  } resp_kind_e;

  // lowest set bit of a way vector
  function automatic logic [WAY_W-1:0] first_way(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/mtc_way_cmp.sv
module mtc_way_cmp #(
  parameter int UTAG_W = 4,
  parameter int PTAG_W = 20
) (
  input  logic              lk_valid,
  input  logic [UTAG_W-1:0] lk_utag,
  input  logic [UTAG_W-1:0] req_utag,
  input  logic              chk_valid,
  input  logic [PTAG_W-1:0] chk_ptag,
  input  logic [PTAG_W-1:0] cur_ptag,
  output logic              utag_hit,
  output logic              ptag_hit
);
  // narrow compare sits on the data-out path, wide compare one cycle later
  assign utag_hit = lk_valid && (lk_utag == req_utag);
  assign ptag_hit = chk_valid && (chk_ptag == cur_ptag);
endmodule

// File: rtl/mtc_plru.sv
module mtc_plru #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      touch_en,
  input  logic [IDX_W-1:0]          touch_set,
  input  logic [mtc_pkg::WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0]          rd_set,
  output logic [mtc_pkg::WAY_W-1:0] victim_way
);
  logic [2:0] bits_q [SETS];
  logic [2:0] rd_bits;

  assign rd_bits    = bits_q[rd_set];
  // R10: bit0 chooses the half, bit1/bit2 the way inside it
  assign victim_way = rd_bits[0] ? {1'b1, rd_bits[2]} : {1'b0, rd_bits[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) bits_q[s] <= 3'b000;
    end else if (touch_en) begin
      bits_q[touch_set][0] <= ~touch_way[1];
      if (touch_way[1]) bits_q[touch_set][2] <= ~touch_way[0];
      else              bits_q[touch_set][1] <= ~touch_way[0];
    end
  end

  // R10: right after a touch the tree never names the touched way
  a_r10_plru_points_away: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && rd_set == touch_set) |=>
      ($stable(rd_set) -> victim_way != $past(touch_way)));
endmodule

// File: rtl/mtc_victim.sv
module mtc_victim (
  input  logic [mtc_pkg::WAYS-1:0]  utag_match,
  input  logic [mtc_pkg::WAYS-1:0]  line_valid,
  input  logic [mtc_pkg::WAY_W-1:0] plru_way,
  output logic [mtc_pkg::WAY_W-1:0] victim
);
  import mtc_pkg::*;
  // R6: a microtag twin must go first, then free ways, then the tree
  always_comb begin
    if (|utag_match)       victim = first_way(utag_match);
    else if (&line_valid)  victim = plru_way;
    else                   victim = first_way(~line_valid);
  end
endmodule

// File: rtl/mtc_lookup.sv
module mtc_lookup #(
  parameter int SETS     = 16,
  parameter int UTAG_W   = 4,
  parameter int PTAG_W   = 20,
  parameter int OFFSET_W = 6,
  parameter int VA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_vaddr_i,
  output logic [3:0]        early_way_o,
  input  logic [PTAG_W-1:0] ptag_i,
  output logic              resp_valid_o,
  output logic [1:0]        resp_kind_o,
  output logic [1:0]        resp_way_o,
  output logic              miss_valid_o,
  output logic [1:0]        miss_way_o,
  input  logic              fill_valid_i,
  output logic              fill_ready_o
);
  import mtc_pkg::*;
  localparam int IDX_W  = $clog2(SETS);
  localparam int UTAG_LO = OFFSET_W + IDX_W;

  logic [WAYS-1:0]   valid_q [SETS];
  logic [UTAG_W-1:0] utag_q  [SETS][WAYS];
  logic [PTAG_W-1:0] ptag_q  [SETS][WAYS];

  logic              b_valid_q;
  logic [IDX_W-1:0]  b_idx_q;
  logic [UTAG_W-1:0] b_utag_q;
  logic [WAYS-1:0]   b_uway_q;
  logic [PTAG_W-1:0] b_ptag_q;
  logic              wait_q;
  logic [WAY_W-1:0]  vic_q;

  logic [IDX_W-1:0]  req_idx;
  logic [UTAG_W-1:0] req_utag;
  logic [WAYS-1:0]   uhit, phit;
  logic              accept, chk_hit, chk_alias, chk_miss, fill_fire;
  logic [WAY_W-1:0]  uway_idx, alias_way, victim, plru_way;
  logic              unused_vaddr;

  assign req_idx      = req_vaddr_i[OFFSET_W +: IDX_W];
  assign req_utag     = req_vaddr_i[UTAG_LO +: UTAG_W];
  assign unused_vaddr = ^req_vaddr_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    mtc_way_cmp #(.UTAG_W(UTAG_W), .PTAG_W(PTAG_W)) u_cmp (
      .lk_valid (valid_q[req_idx][w]),
      .lk_utag  (utag_q[req_idx][w]),
      .req_utag (req_utag),
      .chk_valid(valid_q[b_idx_q][w]),
      .chk_ptag (ptag_q[b_idx_q][w]),
      .cur_ptag (ptag_i),
      .utag_hit (uhit[w]),
      .ptag_hit (phit[w])
    );
  end

  assign req_ready_o  = !wait_q && !b_valid_q;   // R11
  assign accept       = req_valid_i && req_ready_o;
  assign early_way_o  = req_valid_i ? uhit : '0; // R1

  // check stage: confirm the early way, else search the set for an alias
  assign chk_hit   = b_valid_q && |(b_uway_q & phit);
  assign chk_alias = b_valid_q && !chk_hit && |phit;
  assign chk_miss  = b_valid_q && !chk_hit && !chk_alias;
  assign uway_idx  = first_way(b_uway_q);
  assign alias_way = first_way(phit);
  assign fill_fire = wait_q && fill_valid_i;

  mtc_victim u_victim (
    .utag_match(b_uway_q),
    .line_valid(valid_q[b_idx_q]),
    .plru_way  (plru_way),
    .victim    (victim)
  );

  always_comb begin
    resp_valid_o = 1'b0;
    resp_kind_o  = RK_HIT;
    resp_way_o   = uway_idx;
    if (chk_hit) begin
      resp_valid_o = 1'b1;
    end else if (chk_alias) begin
      resp_valid_o = 1'b1;
      resp_kind_o  = RK_ALIAS;
      resp_way_o   = alias_way;
    end else if (fill_fire) begin
      resp_valid_o = 1'b1;
      resp_kind_o  = RK_FILL;
      resp_way_o   = vic_q;
    end
  end

  mtc_plru #(.SETS(SETS)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (resp_valid_o),
    .touch_set (b_idx_q),
    .touch_way (resp_way_o),
    .rd_set    (b_idx_q),
    .victim_way(plru_way)
  );

  assign miss_valid_o = wait_q;
  assign miss_way_o   = vic_q;
  assign fill_ready_o = wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_valid_q <= 1'b0;
      b_idx_q   <= '0;
      b_utag_q  <= '0;
      b_uway_q  <= '0;
      b_ptag_q  <= '0;
      wait_q    <= 1'b0;
      vic_q     <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          utag_q[s][w] <= '0;
          ptag_q[s][w] <= '0;
        end
      end
    end else begin
      b_valid_q <= accept;
      if (accept) begin
        b_idx_q  <= req_idx;
        b_utag_q <= req_utag;
        b_uway_q <= uhit;
      end
      if (chk_alias) begin
        // R4: retag the alias, drop the line that held the new microtag
        utag_q[b_idx_q][alias_way] <= b_utag_q;
        if (|b_uway_q) valid_q[b_idx_q][uway_idx] <= 1'b0;
      end
      if (chk_miss) begin
        wait_q   <= 1'b1;
        vic_q    <= victim;
        b_ptag_q <= ptag_i;
      end
      if (fill_fire) begin
        wait_q                  <= 1'b0;
        valid_q[b_idx_q][vic_q] <= 1'b1;
        utag_q[b_idx_q][vic_q]  <= b_utag_q;
        ptag_q[b_idx_q][vic_q]  <= b_ptag_q;
      end
    end
  end

  a_r8_early_unique: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $onehot0(early_way_o));

  a_r3_no_false_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid_q && |b_uway_q && !(|(b_uway_q & phit)))
      |-> !(resp_valid_o && resp_kind_o == RK_HIT));

  a_r5_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid_o |-> !req_ready_o);

  a_r4_alias_no_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_kind_o == RK_ALIAS) |=> (!miss_valid_o && req_ready_o));

  a_r7_fill_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i && fill_ready_o) |=> (req_ready_o && !miss_valid_o));

  a_r11_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_kind_o != RK_FILL) |-> $past(req_valid_i && req_ready_o));
endmodule

// File: tb/test_mtc_lookup.sv
module test_mtc_lookup;
  localparam int SETS = 4, UTAG_W = 3, PTAG_W = 4, OFFSET_W = 4, VA_W = 16;
  localparam int IDX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid_i = 1'b0, fill_valid_i = 1'b0;
  logic [VA_W-1:0] req_vaddr_i = '0;
  logic [PTAG_W-1:0] ptag_i = '0;
  logic req_ready_o, resp_valid_o, miss_valid_o, fill_ready_o;
  logic [3:0] early_way_o;
  logic [1:0] resp_kind_o, resp_way_o, miss_way_o;

  always #5 clk = ~clk;

  mtc_lookup #(.SETS(SETS), .UTAG_W(UTAG_W), .PTAG_W(PTAG_W),
               .OFFSET_W(OFFSET_W), .VA_W(VA_W)) i_mtc_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .early_way_o(early_way_o), .ptag_i(ptag_i),
    .resp_valid_o(resp_valid_o), .resp_kind_o(resp_kind_o), .resp_way_o(resp_way_o),
    .miss_valid_o(miss_valid_o), .miss_way_o(miss_way_o),
    .fill_valid_i(fill_valid_i), .fill_ready_o(fill_ready_o));

  int checks = 0, errors = 0;
  bit m_valid [SETS][4];
  int m_utag  [SETS][4];
  int m_ptag  [SETS][4];
  bit [2:0] m_plru [SETS];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_uway(int s, int u);
    for (int w = 0; w < 4; w++) if (m_valid[s][w] && m_utag[s][w] == u) return w;
    return -1;
  endfunction

  function automatic int f_alias(int s, int p);
    for (int w = 0; w < 4; w++) if (m_valid[s][w] && m_ptag[s][w] == p) return w;
    return -1;
  endfunction

  function automatic int f_victim(int s, int em);
    if (em >= 0) return em;
    for (int w = 0; w < 4; w++) if (!m_valid[s][w]) return w;
    if (m_plru[s][0]) return m_plru[s][2] ? 3 : 2;
    return m_plru[s][1] ? 1 : 0;
  endfunction

  function automatic void touch(int s, int w);
    m_plru[s][0] = (w < 2);
    if (w < 2) m_plru[s][1] = (w == 0);
    else       m_plru[s][2] = (w == 2);
  endfunction

  task automatic do_req(input int s, input int u, input int p, input int wait_n);
    int em, al, vic, ew;
    em = f_uway(s, u);
    @(negedge clk);
    req_valid_i = 1'b1;
    req_vaddr_i = {7'($urandom), UTAG_W'(u), IDX_W'(s), OFFSET_W'($urandom)};
    #1;
    check("R11 ready before accept", int'(req_ready_o), 1);
    ew = (em >= 0) ? (1 << em) : 0;
    check("R1 early way", int'(early_way_o), ew);
    check("R8 early way unique", int'($countones(early_way_o) <= 1), 1);
    @(negedge clk);
    req_valid_i = 1'b0;
    ptag_i = PTAG_W'(p);
    #1;
    check("R11 ready low in check cycle", int'(req_ready_o), 0);
    if (em >= 0 && m_ptag[s][em] == p) begin
      check("R2 hit valid", int'(resp_valid_o), 1);
      check("R2 hit kind", int'(resp_kind_o), 0);
      check("R2 hit way", int'(resp_way_o), em);
      touch(s, em);
    end else begin
      al = f_alias(s, p);
      if (al >= 0) begin
        check("R4 alias valid", int'(resp_valid_o), 1);
        check("R4 alias kind", int'(resp_kind_o), 1);
        check("R4 alias way", int'(resp_way_o), al);
        m_utag[s][al] = u;
        if (em >= 0) m_valid[s][em] = 1'b0;
        touch(s, al);
        @(negedge clk); #1;
        check("R4 no refill after alias", int'(miss_valid_o), 0);
      end else begin
        vic = f_victim(s, em);
        check("R3 no response on miss", int'(resp_valid_o), 0);
        @(negedge clk); #1;
        check("R5 miss raised", int'(miss_valid_o), 1);
        check("R6 victim way", int'(miss_way_o), vic);
        check("R5 stall during miss", int'(req_ready_o), 0);
        repeat (wait_n) @(negedge clk);
        #1;
        check("R5 miss held", int'(miss_valid_o), 1);
        fill_valid_i = 1'b1;
        #1;
        check("R7 fill ready", int'(fill_ready_o), 1);
        check("R7 fill resp valid", int'(resp_valid_o), 1);
        check("R7 fill resp kind", int'(resp_kind_o), 2);
        check("R7 fill resp way", int'(resp_way_o), vic);
        @(negedge clk);
        fill_valid_i = 1'b0;
        m_valid[s][vic] = 1'b1;
        m_utag[s][vic]  = u;
        m_ptag[s][vic]  = p;
        touch(s, vic);
      end
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      m_plru[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin
        m_valid[s][w] = 1'b0; m_utag[s][w] = 0; m_ptag[s][w] = 0;
      end
    end
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    check("R9 ready", int'(req_ready_o), 1);
    check("R9 resp", int'(resp_valid_o), 0);
    check("R9 miss", int'(miss_valid_o), 0);
    check("R9 fill ready", int'(fill_ready_o), 0);
    rst_n = 1'b1;
    // R6 fills into invalid ways in order, then R2 hits
    for (int u = 0; u < 4; u++) do_req(1, u, u + 1, 1);
    for (int u = 3; u >= 0; u--) do_req(1, u, u + 1, 0);
    // R3 microtag twin with other physical tag: miss, twin is victim
    do_req(1, 2, 9, 2);
    // R4 alias: new microtag, existing physical tag
    do_req(1, 5, 1, 0);
    do_req(1, 5, 1, 0);
    do_req(1, 0, 1, 0);
    // R4 alias whose new microtag is held by another line
    do_req(1, 3, 2, 0);
    // R10 pseudo-LRU choice in a full set without microtag twin
    for (int u = 0; u < 4; u++) do_req(2, u, u + 1, 0);
    do_req(2, 1, 2, 0);
    do_req(2, 3, 4, 0);
    do_req(2, 6, 7, 1);
    do_req(2, 7, 8, 0);
    // random traffic
    for (int i = 0; i < 600; i++)
      do_req(int'($urandom_range(0, SETS - 1)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 15)), int'($urandom_range(0, 3)));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule